// File: doc/BRIEF.md
# Selectable Timebase Prescaler

This block turns a stream of input-clock strobes into an exact one-second tick and a family of sub-second tick pulses. Each strobe is a single-cycle `in_en` pulse in the system clock domain that marks one edge of the timebase source. A source-select field tells the block which source frequency the strobes come from. It can be a 32768 Hz crystal, one of three binary megahertz-class rates (2^20, 2^21 or 2^22 Hz), or a 50 Hz or 60 Hz mains line input. A megahertz source first passes through a power-of-two front divider that brings it down to the 32768 Hz base rate. A binary chain then halves the base rate step by step down to 1 Hz. A line source uses a modulo-50 or modulo-60 counter instead.

The binary chain is exported as a vector of tap pulses, so that a periodic-interrupt stage can pick any sub-second rate. A second select field drives a buffered square-wave output from one of seven chain bits, or holds the output low. Changing the source selection restarts all dividers, so that no partial first second is produced.

Top module: `timebase_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick_1hz`, `taps` and `clk_out` are all 0 from the first clock edge onward.
- R2: With `src_sel` = 0 (32768 Hz base), `tick_1hz` pulses for one cycle once every 2^BASE_BITS accepted strobes. The pulse is high in the cycle after the clock edge that accepted the final strobe of the second.
- R3: With `src_sel` = 1, 2 or 3, the front divider multiplies the period by 2^FRONT_SH1, 2^FRONT_SH2 or 2^FRONT_SH3 respectively. With the default parameters this gives a 1 Hz tick from 2^20, 2^21 or 2^22 strobes per second.
- R4: In a binary mode, bit i of `taps` pulses for one cycle once every F·2^(i+1) accepted strobes, where F is the front divide ratio (1 for `src_sel` = 0). Bit BASE_BITS-1 coincides with `tick_1hz`.
- R5: With `src_sel[2]` = 1 (line mode), `tick_1hz` pulses once every LINE_A strobes (50 by default) when `line_60` = 0, and once every LINE_B strobes (60 by default) when `line_60` = 1. All `taps` bits stay 0 in line mode.
- R6: `out_sel` = 0 holds `clk_out` low. A code c from 1 to 7 drives `clk_out` with bit min(2·(c-1), BASE_BITS-1) of the binary chain count. The output is registered, so it shows the count as it stood before each clock edge.
- R7: An edge at which `src_sel` or `line_60` differs from the value held since the previous edge clears every divider. The strobe on that edge is discarded and no tick or tap fires on it.
- R8: Without an accepted strobe, neither `tick_1hz` nor any `taps` bit pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_en | input | 1 | One-cycle strobe per timebase source edge |
| src_sel | input | 3 | Source frequency: 0 = 32768 Hz, 1 = 2^20, 2 = 2^21, 3 = 2^22 Hz, 4..7 = line |
| line_60 | input | 1 | Line rate in line mode: 0 = 50 Hz, 1 = 60 Hz |
| out_sel | input | 3 | Buffered clock output select, 0 = low |
| tick_1hz | output | 1 | One-cycle pulse per second |
| taps | output | BASE_BITS | One-cycle pulses from each binary chain stage |
| clk_out | output | 1 | Buffered divided clock output |

## Verification
A strobe accepted at clock edge k produces its `tick_1hz` and `taps` pulses in the cycle that follows edge k, and no later. `clk_out` reflects the chain count as it stood just before edge k. A source change takes effect on the very edge where it is first seen. The reference model advances on each rising edge from the same inputs, and the bench compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Per-phase tick totals are also checked against the strobe count divided by the expected period. These totals cover each source, a second interrupted by a select change, and a stretch with no strobes.

// File: rtl/tbp_pkg.sv
// Package: shared constants and helpers of the timebase prescaler.
// Assumes: source codes 0..3 are binary rates and any code with bit 2 set is line input.
package tbp_pkg;

    localparam int SRC_W = 3;
    localparam int SEL_W = 3;

    // Binary source selections, as carried on src_sel.
    typedef enum logic [1:0] {
        SRC_BASE = 2'd0,
        SRC_MHZ1 = 2'd1,
        SRC_MHZ2 = 2'd2,
        SRC_MHZ4 = 2'd3
    } bin_src_e;

    // Chain bit that an output-select code drives, clamped to the chain width.
    function automatic int clk_tap_index(input int code, input int width);
        int idx;
        idx = 2 * (code - 1);
        if (idx > width - 1) idx = width - 1;
        if (idx < 0) idx = 0;
        return idx;
    endfunction

    // Largest of three shift amounts.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/front_prescaler.sv
// Module: front_prescaler
// Divides the incoming strobe stream by 1, 2^SH1, 2^SH2 or 2^SH3, so that the
// following chain always runs at the base rate.
// Assumes: each shift is at least 1; clr has priority over counting.
module front_prescaler
    import tbp_pkg::*;
#(
    parameter int SH1 = 5,
    parameter int SH2 = 6,
    parameter int SH3 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  bin_src_e   sel,
    output logic       base_stb
);

    localparam int FW = max3(SH1, SH2, SH3);

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] mask;

    // Pick the low-bit mask that marks the end of one divide period.
    always_comb begin
        unique case (sel)
            SRC_BASE: mask = '0;
            SRC_MHZ1: mask = FW'((1 << SH1) - 1);
            SRC_MHZ2: mask = FW'((1 << SH2) - 1);
            default:  mask = FW'((1 << SH3) - 1);
        endcase
    end

    assign base_stb = en && !clr && ((cnt_q & mask) == mask);

    // Count accepted strobes; wrapping at 2^FW is a multiple of every ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/binary_chain.sv
// Module: binary_chain
// Ripple-free binary divider of W stages clocked by base-rate strobes. It
// exports the running count and one registered pulse per stage boundary.
// Assumes: stb is already gated by clear; clr zeroes both count and pulses.
module binary_chain #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb,
    output logic [W-1:0] count,
    output logic [W-1:0] taps
);

    logic [W-1:0] count_q;
    logic [W-1:0] tap_q;

    // Advance the chain once per base-rate strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (stb) begin
            count_q <= count_q + 1'b1;
        end
    end

    // One pulse register per stage: fires when all lower bits roll over.
    for (genvar i = 0; i < W; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                tap_q[i] <= 1'b0;
            end else begin
                tap_q[i] <= stb && (&count_q[i:0]);
            end
        end
    end

    assign count = count_q;
    assign taps  = tap_q;

endmodule

// File: rtl/line_divider.sv
// Module: line_divider
// Modulo counter for mains-frequency input: one registered pulse every
// MOD_A or MOD_B strobes, chosen by sel_b.
// Assumes: both moduli are at least 2; clr restarts the count at zero.
module line_divider #(
    parameter int MOD_A = 50,
    parameter int MOD_B = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sel_b,
    output logic tick
);

    localparam int MOD_MAX = (MOD_A > MOD_B) ? MOD_A : MOD_B;
    localparam int CW      = $clog2(MOD_MAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          tick_q;
    logic          wrap;

    assign last = sel_b ? CW'(MOD_B - 1) : CW'(MOD_A - 1);
    assign wrap = en && (cnt_q == last);

    // Count line cycles and restart at the selected modulus.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the once-per-second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/clkout_mux.sv
// Module: clkout_mux
// Registered selector for the buffered clock output: code 0 drives low and
// codes 1..7 drive one chain bit each.
// Assumes: the chain count is a registered value; the output lags it by one edge.
module clkout_mux
    import tbp_pkg::*;
#(
    parameter int W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     count,
    output logic             clk_out
);

    localparam int NCODE = 1 << SEL_W;

    logic [NCODE-1:0] cand;
    logic             out_q;

    // Build the candidate bit for every select code.
    assign cand[0] = 1'b0;
    for (genvar c = 1; c < NCODE; c++) begin : g_cand
        localparam int IDX = clk_tap_index(c, W);
        assign cand[c] = count[IDX];
    end

    // Register the selected candidate to give a glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= cand[sel];
        end
    end

    assign clk_out = out_q;

endmodule

// File: rtl/timebase_prescaler.sv
// Module: timebase_prescaler (top)
// Converts input-clock strobes of a selectable source frequency into a 1 Hz
// tick, per-stage sub-second pulses and a buffered divided clock output.
// Assumes: in_en is a single-cycle strobe already in the clk domain; any
// change of source or line rate restarts all dividers on that edge.
module timebase_prescaler
    import tbp_pkg::*;
#(
    parameter int BASE_BITS = 15,
    parameter int FRONT_SH1 = 5,
    parameter int FRONT_SH2 = 6,
    parameter int FRONT_SH3 = 7,
    parameter int LINE_A    = 50,
    parameter int LINE_B    = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_en,
    input  logic [SRC_W-1:0]     src_sel,
    input  logic                 line_60,
    input  logic [SEL_W-1:0]     out_sel,
    output logic                 tick_1hz,
    output logic [BASE_BITS-1:0] taps,
    output logic                 clk_out
);

    logic [SRC_W-1:0]     src_q;
    logic                 l60_q;
    logic                 clr;
    logic                 line_mode;
    logic                 base_stb;
    logic                 line_tick;
    logic [BASE_BITS-1:0] chain_cnt;
    logic [BASE_BITS-1:0] chain_taps;
    bin_src_e             bin_sel;

    assign clr       = (src_sel != src_q) || (line_60 != l60_q);
    assign line_mode = src_q[SRC_W-1];
    assign bin_sel   = bin_src_e'(src_q[1:0]);

    // Hold the selection seen at the last edge to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            l60_q <= 1'b0;
        end else begin
            src_q <= src_sel;
            l60_q <= line_60;
        end
    end

    front_prescaler #(
        .SH1 (FRONT_SH1),
        .SH2 (FRONT_SH2),
        .SH3 (FRONT_SH3)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (in_en && !line_mode),
        .sel      (bin_sel),
        .base_stb (base_stb)
    );

    binary_chain #(
        .W (BASE_BITS)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .stb   (base_stb),
        .count (chain_cnt),
        .taps  (chain_taps)
    );

    line_divider #(
        .MOD_A (LINE_A),
        .MOD_B (LINE_B)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (in_en && line_mode),
        .sel_b (l60_q),
        .tick  (line_tick)
    );

    clkout_mux #(
        .W (BASE_BITS)
    ) u_clkout (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (out_sel),
        .count   (chain_cnt),
        .clk_out (clk_out)
    );

    // Only one of the two sources can pulse in a given mode.
    assign tick_1hz = line_tick | chain_taps[BASE_BITS-1];
    assign taps     = chain_taps;

endmodule

// File: rtl/tbp_checker.sv
// Module: tbp_checker
// Temporal properties of timebase_prescaler, attached through bind.
// Assumes: it observes the top module's ports only.
module tbp_checker #(
    parameter int W = 15
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_en,
    input logic [2:0]   src_sel,
    input logic         line_60,
    input logic [2:0]   out_sel,
    input logic         tick_1hz,
    input logic [W-1:0] taps,
    input logic         clk_out
);

    // R1: outputs are quiet in the cycle after a reset edge.
    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!tick_1hz && taps == '0 && !clk_out));

    // R8: a tick needs a strobe on the previous edge.
    assert_tick_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz || taps != '0) |-> $past(in_en));

    // R5: taps stay silent in line mode.
    assert_taps_quiet_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src_sel[2]) |-> (taps == '0));

    // R4: the top chain stage is the seconds tick in binary modes.
    assert_top_tap_is_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(src_sel[2]) |-> (taps[W-1] == tick_1hz));

    // R6: select code zero holds the output low.
    assert_clkout_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_sel) == 3'd0) |-> !clk_out);

    // R7: no pulse on an edge where the selection changed.
    assert_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         ($past(src_sel) != $past(src_sel, 2) || $past(line_60) != $past(line_60, 2)))
        |-> (!tick_1hz && taps == '0));

endmodule

bind timebase_prescaler tbp_checker #(.W(BASE_BITS)) u_tbp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_en    (in_en),
    .src_sel  (src_sel),
    .line_60  (line_60),
    .out_sel  (out_sel),
    .tick_1hz (tick_1hz),
    .taps     (taps),
    .clk_out  (clk_out)
);

// File: tb/timebase_prescaler_tb.sv
// Bench: behavioural reference model compared on every clock.
module timebase_prescaler_tb;

    localparam int W   = 8;
    localparam int SH1 = 5;
    localparam int SH2 = 6;
    localparam int SH3 = 7;
    localparam int LA  = 50;
    localparam int LB  = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_en = 1'b0;
    logic [2:0]   src_sel = 3'd0;
    logic         line_60 = 1'b0;
    logic [2:0]   out_sel = 3'd0;
    logic         tick_1hz;
    logic [W-1:0] taps;
    logic         clk_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    timebase_prescaler #(
        .BASE_BITS (W),
        .FRONT_SH1 (SH1),
        .FRONT_SH2 (SH2),
        .FRONT_SH3 (SH3),
        .LINE_A    (LA),
        .LINE_B    (LB)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_en    (in_en),
        .src_sel  (src_sel),
        .line_60  (line_60),
        .out_sel  (out_sel),
        .tick_1hz (tick_1hz),
        .taps     (taps),
        .clk_out  (clk_out)
    );

    // Reference model state.
    longint       m_n = 0;
    int           m_l = 0;
    logic [2:0]   m_src = 3'd0;
    logic         m_l60 = 1'b0;
    logic         e_tick = 1'b0;
    logic [W-1:0] e_taps = '0;
    logic         e_clk = 1'b0;

    function automatic longint front_ratio(input logic [2:0] s);
        case (s)
            3'd1:    return longint'(1) << SH1;
            3'd2:    return longint'(1) << SH2;
            3'd3:    return longint'(1) << SH3;
            default: return 1;
        endcase
    endfunction

    function automatic int out_bit(input int code);
        int b;
        b = 2 * code - 2;
        return (b > W - 1) ? W - 1 : b;
    endfunction

    // Advance the model by one clock edge from the inputs seen at that edge.
    always @(posedge clk) begin
        longint f;
        if (!rst_n) begin
            m_n = 0; m_l = 0; m_src = 3'd0; m_l60 = 1'b0;
            e_tick = 1'b0; e_taps = '0; e_clk = 1'b0;
        end else begin
            f = front_ratio(m_src);
            if (out_sel == 3'd0) e_clk = 1'b0;
            else e_clk = ((m_n / f) >> out_bit(int'(out_sel))) & 1;
            e_tick = 1'b0;
            e_taps = '0;
            if (src_sel != m_src || line_60 != m_l60) begin
                m_n = 0; m_l = 0; m_src = src_sel; m_l60 = line_60;
            end else if (in_en) begin
                if (!m_src[2]) begin
                    m_n++;
                    for (int i = 0; i < W; i++)
                        if (m_n % (f << (i + 1)) == 0) e_taps[i] = 1'b1;
                    e_tick = e_taps[W-1];
                end else begin
                    m_l++;
                    if (m_l == (m_l60 ? LB : LA)) begin
                        m_l = 0;
                        e_tick = 1'b1;
                    end
                end
            end
        end
    end

    int dut_ticks = 0;

    // Wait to the falling edge and compare every output with the model.
    task automatic step();
        @(negedge clk);
        cycles++;
        if (tick_1hz) dut_ticks++;
        checks++;
        if (tick_1hz !== e_tick) begin
            errors++;
            $display("FAIL %s tick_1hz actual=%b expected=%b cycle=%0d", cur_req, tick_1hz, e_tick, cycles);
        end
        checks++;
        if (taps !== e_taps) begin
            errors++;
            $display("FAIL %s taps actual=%h expected=%h cycle=%0d",
                     (cur_req == "R1") ? "R1" : (m_src[2] ? "R5" : "R4"), taps, e_taps, cycles);
        end
        checks++;
        if (clk_out !== e_clk) begin
            errors++;
            $display("FAIL %s clk_out actual=%b expected=%b cycle=%0d",
                     (cur_req == "R1") ? "R1" : "R6", clk_out, e_clk, cycles);
        end
    endtask

    logic [15:0] lfsr = 16'hACE1;

    // Drive strobes for n cycles (always on or pseudo-random) and return the count.
    task automatic run(input int n, input bit rnd, output int strobes);
        strobes = 0;
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_en = rnd ? (lfsr[0] | lfsr[3]) : 1'b1;
            if (in_en) strobes++;
            step();
        end
        in_en = 1'b0;
        step();
    endtask

    // Apply a new selection with no strobe on the clearing edge.
    task automatic select(input logic [2:0] s, input logic l, input logic [2:0] o);
        src_sel = s; line_60 = l; out_sel = o; in_en = 1'b0;
        step();
        dut_ticks = 0;
    endtask

    task automatic check_count(input string req, input int got, input int exp_v);
        checks++;
        if (got != exp_v) begin
            errors++;
            $display("FAIL %s tick count actual=%0d expected=%0d", req, got, exp_v);
        end
    endtask

    int s;
    int s2;

    initial begin
        // R1: reset state.
        cur_req = "R1";
        for (int k = 0; k < 4; k++) step();
        @(negedge clk) rst_n = 1'b1;

        // R2: base source, continuous then random strobes.
        cur_req = "R2";
        select(3'd0, 1'b0, 3'd1);
        run(600, 1'b0, s);
        check_count("R2", dut_ticks, s / (1 << W));
        out_sel = 3'd3;
        dut_ticks = 0;
        run(1500, 1'b1, s2);
        check_count("R2", dut_ticks, (s + s2) / (1 << W) - s / (1 << W));

        // R5: line input at both rates.
        cur_req = "R5";
        select(3'd4, 1'b0, 3'd4);
        run(700, 1'b1, s);
        check_count("R5", dut_ticks, s / LA);
        select(3'd4, 1'b1, 3'd4);
        run(610, 1'b0, s);
        check_count("R5", dut_ticks, s / LB);

        // R3: each megahertz-class source.
        cur_req = "R3";
        select(3'd1, 1'b0, 3'd5);
        run(8300, 1'b0, s);
        check_count("R3", dut_ticks, s / ((1 << SH1) << W));
        select(3'd2, 1'b0, 3'd7);
        run(16500, 1'b0, s);
        check_count("R3", dut_ticks, s / ((1 << SH2) << W));
        select(3'd3, 1'b0, 3'd2);
        run(33000, 1'b0, s);
        check_count("R3", dut_ticks, s / ((1 << SH3) << W));

        // R6: output held low with code 0 while the chain runs.
        cur_req = "R6";
        select(3'd0, 1'b0, 3'd0);
        run(1000, 1'b1, s);
        check_count("R6", dut_ticks, s / (1 << W));

        // R7: a select change part-way through a second restarts it.
        cur_req = "R7";
        select(3'd0, 1'b0, 3'd6);
        run(200, 1'b0, s);
        select(3'd0, 1'b1, 3'd6);
        run((1 << W) - 1, 1'b0, s);
        check_count("R7", dut_ticks, 0);
        run(1, 1'b0, s);
        check_count("R7", dut_ticks, 1);
        run(150, 1'b0, s);
        select(3'd1, 1'b1, 3'd6);
        select(3'd0, 1'b1, 3'd6);
        run(1 << W, 1'b0, s);
        check_count("R7", dut_ticks, 1);

        // R8: no strobes, no pulses.
        cur_req = "R8";
        dut_ticks = 0;
        in_en = 1'b0;
        for (int k = 0; k < 400; k++) step();
        check_count("R8", dut_ticks, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule